// File: doc/BRIEF.md
# Mantissa Rounding Stage

This block takes an unpacked floating-point mantissa that still carries two extra low-order bits, plus a separate sticky bit, the value's sign and a rounding-mode select. It removes the two extra bits and decides from the mode whether the remaining mantissa must be bumped by one unit in its last place. Bit 1 of the incoming mantissa is the guard bit, bit 0 is the round bit, and bit 2 becomes the least significant bit of the result.

The result comes out one bit wider than the shifted mantissa. An increment that carries all the way through the mantissa therefore appears as a set top bit, which is the 2.0 case, and it is not corrected here. A packer placed after this stage renormalizes the mantissa and adjusts the exponent. Two flags come with the mantissa. One reports that an increment was applied. The other reports that any of the discarded bits, or the sticky bit, was nonzero.

The decision logic is combinational. It sits in front of one register stage with no handshake, so each input set shows up at the outputs on the next rising clock edge.

Top module: `mant_round_unit`

## Requirements
- R1: While reset is high, and on the first cycle after it, the registered mantissa, round-up flag and inexact flag are all zero.
- R2: When the guard, round and sticky bits are all zero, the output mantissa equals the input shifted right by two. Both the round-up flag and the inexact flag are 0, whatever the mode.
- R3: When guard, round or sticky is 1, the inexact flag is 1, whether or not an increment happens.
- R4: With mode 00 (nearest), the unit increments only when guard is 1 and at least one of round, sticky or the shifted LSB (input bit 2) is 1. An exact tie therefore rounds to even.
- R5: With mode 01 (toward zero), the unit never increments.
- R6: With mode 10 (toward minus infinity), the unit increments exactly when the result is inexact and the sign is 1.
- R7: With mode 11 (toward plus infinity), the unit increments exactly when the result is inexact and the sign is 0.
- R8: The increment carries through every mantissa bit. An all-ones shifted mantissa that is incremented gives an output with only its top bit (bit MANT_W-2) set.
- R9: The round-up flag is 1 exactly when the output mantissa equals the shifted input plus one. Otherwise the output equals the shifted input.
- R10: The outputs reflect the inputs sampled at the previous rising clock edge, a latency of exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inMant | input | MANT_W | Mantissa; bit 1 is guard, bit 0 is round |
| inSticky | input | 1 | Sticky bit from earlier shifts |
| inSign | input | 1 | Sign of the value, 1 = negative |
| inMode | input | 2 | Rounding mode: 00 nearest, 01 zero, 10 minus inf, 11 plus inf |
| outMant | output | MANT_W-1 | Rounded mantissa; the top bit is the carry-out |
| outRoundUp | output | 1 | An increment was applied |
| outInexact | output | 1 | Discarded bits or sticky were nonzero |

## Verification
The hardest case to reach is a carry that runs the full length of the mantissa and ends in the top output bit. It needs an all-ones mantissa together with a rounding decision that increments. The stimulus table builds this case twice. The first uses nearest mode with guard and round set above an all-ones field. The second uses plus-infinity mode above a field that is all ones except its top bit, so the carry stops exactly one position lower. The exact-tie case is also covered with both even and odd LSBs, and each directed mode is exercised with both signs.

// File: rtl/mant_round_pkg.sv
package mant_round_pkg;
  typedef enum logic [1:0] {
    RND_NEAREST = 2'b00,
    RND_ZERO    = 2'b01,
    RND_DOWN    = 2'b10,
    RND_UP      = 2'b11
  } rnd_mode_e;

  typedef struct packed {
    logic inexact;
    logic bumpUp;
  } rnd_strobe_t;
endpackage

// File: rtl/mant_round_ctrl.sv
module mant_round_ctrl
  import mant_round_pkg::*;
(
  input  logic        guardBit,
  input  logic        roundBit,
  input  logic        stickyBit,
  input  logic        lsbBit,
  input  logic        signBit,
  input  logic [1:0]  modeSel,
  output rnd_strobe_t strobes
);
  rnd_mode_e mode;
  logic      anyLost;
  logic      wantUp;

  always_comb begin
    mode    = rnd_mode_e'(modeSel);
    anyLost = guardBit | roundBit | stickyBit;
    unique case (mode)
      RND_ZERO: wantUp = 1'b0;
      RND_DOWN: wantUp = signBit;
      RND_UP:   wantUp = ~signBit;
      default:  wantUp = guardBit & (roundBit | stickyBit | lsbBit);
    endcase
    strobes.inexact = anyLost;
    strobes.bumpUp  = anyLost & wantUp;
  end
endmodule

// File: rtl/mant_round_dp.sv
module mant_round_dp
  import mant_round_pkg::*;
#(
  parameter int MANT_W = 26
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MANT_W-1:0] mantIn,
  input  logic              stickyIn,
  input  logic              signIn,
  input  logic [1:0]        modeIn,
  input  rnd_strobe_t       strobes,
  output logic [MANT_W-2:0] mantOut,
  output logic              roundUpOut,
  output logic              inexactOut
);
  localparam int RES_W = MANT_W - 1;

  logic [RES_W-1:0] shifted;
  logic [RES_W-1:0] bumped;

  always_comb begin
    shifted = {1'b0, mantIn[MANT_W-1:2]};
    bumped  = shifted + {{(RES_W-1){1'b0}}, strobes.bumpUp};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mantOut    <= '0;
      roundUpOut <= 1'b0;
      inexactOut <= 1'b0;
    end else begin
      mantOut    <= bumped;
      roundUpOut <= strobes.bumpUp;
      inexactOut <= strobes.inexact;
    end
  end

  p_reset_zero_r1: assert property (@(posedge clk)
    $past(rst) |-> (mantOut == '0 && !roundUpOut && !inexactOut));

  p_exact_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mantIn[1:0] == 2'b00 && !stickyIn))
      |-> (!inexactOut && !roundUpOut && mantOut == $past(shifted)));

  p_inexact_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mantIn[1:0] != 2'b00 || stickyIn)) |-> inexactOut);

  p_nearest_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(modeIn == 2'b00 && !mantIn[1])) |-> !roundUpOut);

  p_no_bump_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(modeIn == 2'b01)) |-> !roundUpOut);

  p_down_sign_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(modeIn == 2'b10 && !signIn)) |-> !roundUpOut);

  p_up_sign_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(modeIn == 2'b11 && signIn)) |-> !roundUpOut);

  p_bump_value_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && roundUpOut) |-> (mantOut == $past(shifted) + 1'b1));
endmodule

// File: rtl/mant_round_unit.sv
module mant_round_unit
  import mant_round_pkg::*;
#(
  parameter int MANT_W = 26
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MANT_W-1:0] inMant,
  input  logic              inSticky,
  input  logic              inSign,
  input  logic [1:0]        inMode,
  output logic [MANT_W-2:0] outMant,
  output logic              outRoundUp,
  output logic              outInexact
);
  rnd_strobe_t strobes;

  mant_round_ctrl u_ctrl (
    .guardBit (inMant[1]),
    .roundBit (inMant[0]),
    .stickyBit(inSticky),
    .lsbBit   (inMant[2]),
    .signBit  (inSign),
    .modeSel  (inMode),
    .strobes  (strobes)
  );

  mant_round_dp #(.MANT_W(MANT_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .mantIn    (inMant),
    .stickyIn  (inSticky),
    .signIn    (inSign),
    .modeIn    (inMode),
    .strobes   (strobes),
    .mantOut   (outMant),
    .roundUpOut(outRoundUp),
    .inexactOut(outInexact)
  );
endmodule

// File: tb/sim_mant_round_unit.sv
`timescale 1ns/1ps
module sim_mant_round_unit;
  localparam int MW = 26;
  localparam int RW = MW - 1;

  typedef struct packed {
    logic [MW-1:0] mant;
    logic          sticky;
    logic          sign;
    logic [1:0]    mode;
    logic [RW-1:0] expMant;
    logic          expUp;
    logic          expInx;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{26'h0000004, 1'b0, 1'b0, 2'b00, 25'h0000001, 1'b0, 1'b0}, // R2 exact
    '{26'h0000006, 1'b0, 1'b0, 2'b00, 25'h0000002, 1'b1, 1'b1}, // R4 tie odd
    '{26'h000000A, 1'b0, 1'b0, 2'b00, 25'h0000002, 1'b0, 1'b1}, // R4 tie even
    '{26'h0000009, 1'b0, 1'b0, 2'b00, 25'h0000002, 1'b0, 1'b1}, // R4 guard 0
    '{26'h000000B, 1'b0, 1'b0, 2'b00, 25'h0000003, 1'b1, 1'b1}, // R4 above half
    '{26'h0000008, 1'b1, 1'b0, 2'b00, 25'h0000002, 1'b0, 1'b1}, // R3 sticky only
    '{26'h000000A, 1'b1, 1'b0, 2'b00, 25'h0000003, 1'b1, 1'b1}, // R4 sticky breaks tie
    '{26'h000000B, 1'b0, 1'b0, 2'b01, 25'h0000002, 1'b0, 1'b1}, // R5
    '{26'h0000009, 1'b0, 1'b1, 2'b10, 25'h0000003, 1'b1, 1'b1}, // R6 negative
    '{26'h0000009, 1'b0, 1'b0, 2'b10, 25'h0000002, 1'b0, 1'b1}, // R6 positive
    '{26'h0000009, 1'b0, 1'b0, 2'b11, 25'h0000003, 1'b1, 1'b1}, // R7 positive
    '{26'h0000009, 1'b0, 1'b1, 2'b11, 25'h0000002, 1'b0, 1'b1}, // R7 negative
    '{26'h3FFFFFF, 1'b0, 1'b0, 2'b00, 25'h1000000, 1'b1, 1'b1}, // R8 full carry
    '{26'h0000008, 1'b0, 1'b1, 2'b10, 25'h0000002, 1'b0, 1'b0}, // R2 exact directed
    '{26'h1FFFFFD, 1'b0, 1'b0, 2'b11, 25'h0800000, 1'b1, 1'b1}, // R8 ripple
    '{26'h3FFFFFC, 1'b0, 1'b0, 2'b11, 25'h0FFFFFF, 1'b0, 1'b0}  // R2 all ones exact
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [MW-1:0] inMant = '0;
  logic          inSticky = 1'b0;
  logic          inSign = 1'b0;
  logic [1:0]    inMode = 2'b00;
  logic [RW-1:0] outMant;
  logic          outRoundUp;
  logic          outInexact;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  mant_round_unit #(.MANT_W(MW)) u0 (
    .clk(clk), .rst(rst), .inMant(inMant), .inSticky(inSticky),
    .inSign(inSign), .inMode(inMode), .outMant(outMant),
    .outRoundUp(outRoundUp), .outInexact(outInexact)
  );

  task automatic check(input string req, input logic [RW-1:0] m, input logic u, input logic x);
    checks++;
    if (outMant !== m || outRoundUp !== u || outInexact !== x) begin
      errors++;
      $display("FAIL %s: got mant=%h up=%b inx=%b expected mant=%h up=%b inx=%b",
               req, outMant, outRoundUp, outInexact, m, u, x);
    end
  endtask

  task automatic drive(input vec_t v);
    inMant = v.mant; inSticky = v.sticky; inSign = v.sign; inMode = v.mode;
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", '0, 1'b0, 1'b0);
    drive(VECS[12]);
    rst = 1'b0;
    @(negedge clk);
    // R1: the first edge with reset low loads VECS[12]
    check("R10 first load", VECS[12].expMant, VECS[12].expUp, VECS[12].expInx);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i]);
      @(negedge clk);
      check($sformatf("R2-vector %0d (see table tag)", i),
            VECS[i].expMant, VECS[i].expUp, VECS[i].expInx);
      // R9: the round-up flag matches the mantissa delta
      checks++;
      if ((outMant == RW'(VECS[i].mant >> 2) + RW'(1)) !== outRoundUp) begin
        errors++;
        $display("FAIL R9 vec %0d: got up=%b expected consistent with mant=%h",
                 i, outRoundUp, outMant);
      end
    end

    // R10: a new input appears only after one edge
    @(negedge clk);
    drive(VECS[1]);
    #1;
    check("R10 before edge", VECS[NV-1].expMant, VECS[NV-1].expUp, VECS[NV-1].expInx);
    @(negedge clk);
    check("R10 after edge", VECS[1].expMant, VECS[1].expUp, VECS[1].expInx);

    // R1: a reset in mid-stream clears the outputs
    drive(VECS[12]);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid reset", '0, 1'b0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R8 after reset", 25'h1000000, 1'b1, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule